// File: doc/BRIEF.md
# Five-Pin GPIO Port with Repurposed Control Bits

This block is a register-mapped bidirectional I/O port with five physical pins. A simple CPU bus reads and writes three 8-bit registers: a data register, a direction register and an output-latch register. Each pin has a direction bit, where 1 makes the pin an input and 0 makes it an output, and an output-latch bit. Pin levels come back to the bus through a two-flop synchronizer. Peripherals can take over a pin through per-pin override inputs. An active override sets the pin's direction and output value, but it never changes the stored direction register. Software can therefore read-modify-write that register safely.

The three upper bits of each register have no pin behind them, so they are used as control outputs. The upper data bits are active-low weak pull-up enables for three other ports. The upper direction bits turn on open-drain mode for three peripheral outputs. The two top latch bits turn on open-drain mode for two serial ports. Latch bit 5 is not implemented. The top latch bit also puts pin 1 into open-drain mode while the serial peripheral owns that pin.

Top module: `gpio_five_pin_port`

## Requirements
- R1: After reset, the direction register reads 0x1F, the latch register reads 0x00, data-register bits 7:5 read 1, `pullUpEnN` is 3'b111, `periphOdEn` and `serialOdEn` are 0, and no pin is driven (`padOe` = 0).
- R2: With no override active, a pin whose direction bit is 0 has `padOe` = 1 and drives its latch bit on `padOut`. A pin whose direction bit is 1 has `padOe` = 0.
- R3: A write to address 0 (data) loads bits 4:0 into the output latches. A write to address 2 (latch) also loads them. Reading address 2 returns the stored latch bits.
- R4: Reading address 0 returns in bits 4:0 the pad levels as they were two rising clock edges before the read. After only one edge, the read still shows the older value.
- R5: Data-register bits 7:5 are written by an address-0 write, read back at address 0, and drive `pullUpEnN[2:0]` directly. A 0 enables the pull-up.
- R6: Direction-register bits 7:5 are written and read at address 1 and drive `periphOdEn[2:0]`.
- R7: Latch bits 7:6 are written and read at address 2 and drive `serialOdEn[1:0]`. Latch bit 5 always reads 0, even after a 1 is written to it.
- R8: When `ovrEn[i]` is 1, pin i takes its output enable from `~ovrDir[i]` and its output value from `ovrOut[i]`, whatever the register contents.
- R9: An active override never changes the direction register. Address 1 reads back the value last written by software.
- R10: When `serialOwnsPin1` is 1 and latch bit 7 is 1, pin 1 is open-drain. In this mode `padOut[1]` is 0, and when pin 1 acts as an output, `padOe[1]` is 1 only while its output value is 0.
- R11: Address 3 reads 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busAddr | input | 2 | Register select: 0 data, 1 direction, 2 latch, 3 none |
| busWrEn | input | 1 | Write strobe for the selected register |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for the selected register (combinational) |
| padIn | input | 5 | Pin levels from the pads |
| padOut | output | 5 | Output value to the pads |
| padOe | output | 5 | Pad output enable, 1 = drive |
| ovrEn | input | 5 | Per-pin peripheral override enable |
| ovrDir | input | 5 | Override direction, 1 = input |
| ovrOut | input | 5 | Override output value |
| serialOwnsPin1 | input | 1 | Serial peripheral currently owns pin 1 |
| pullUpEnN | output | 3 | Active-low pull-up enables for three other ports |
| periphOdEn | output | 3 | Open-drain enables for three peripheral outputs |
| serialOdEn | output | 2 | Open-drain enables for two serial ports |

## Verification
A wrong register bit shows up at the control outputs (`pullUpEnN`, `periphOdEn`, `serialOdEn`, `padOe`) in the cycle after the write that set it. It also shows up at once on a read of that address. An override that leaked into the direction register would still be visible on an address-1 read after the override is dropped. A synchronizer with the wrong depth shows the new pad level one edge too early or too late, so the bench samples the data read both after one edge and after two. Open-drain errors on pin 1 appear directly as a driven high level or as a missing low drive.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_DIR  = 2'd1,
    ADDR_LAT  = 2'd2,
    ADDR_NONE = 2'd3
  } regAddrE;

  typedef struct packed {
    logic    wrData;
    logic    wrDir;
    logic    wrLat;
    regAddrE rdSel;
  } ctrlStrobeT;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic [1:0] busAddr,
  input  logic       busWrEn,
  output ctrlStrobeT strobe
);
  regAddrE addrSel;

  always_comb begin
    addrSel       = regAddrE'(busAddr);
    strobe.wrData = busWrEn && (addrSel == ADDR_DATA);
    strobe.wrDir  = busWrEn && (addrSel == ADDR_DIR);
    strobe.wrLat  = busWrEn && (addrSel == ADDR_LAT);
    strobe.rdSel  = addrSel;
  end
endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 5,
  parameter int REG_WIDTH = 8,
  parameter int OD_PIN    = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobeT           strobe,
  input  logic [REG_WIDTH-1:0] busWrData,
  output logic [REG_WIDTH-1:0] busRdData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  input  logic [PIN_COUNT-1:0] ovrEn,
  input  logic [PIN_COUNT-1:0] ovrDir,
  input  logic [PIN_COUNT-1:0] ovrOut,
  input  logic                 serialOwnsPin1,
  output logic [REG_WIDTH-PIN_COUNT-1:0] pullUpEnN,
  output logic [REG_WIDTH-PIN_COUNT-1:0] periphOdEn,
  output logic [REG_WIDTH-PIN_COUNT-2:0] serialOdEn
);
  localparam int EXTRA    = REG_WIDTH - PIN_COUNT;
  localparam int SER_OD_W = EXTRA - 1;

  logic [PIN_COUNT-1:0] pinLat;
  logic [EXTRA-1:0]     pullBits;
  logic [REG_WIDTH-1:0] dirReg;
  logic [SER_OD_W-1:0]  serOd;
  logic [PIN_COUNT-1:0] syncA, syncB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinLat   <= '0;
      pullBits <= '1;
      dirReg   <= {{EXTRA{1'b0}}, {PIN_COUNT{1'b1}}};
      serOd    <= '0;
      syncA    <= '0;
      syncB    <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      if (strobe.wrData) begin
        pinLat   <= busWrData[PIN_COUNT-1:0];
        pullBits <= busWrData[REG_WIDTH-1:PIN_COUNT];
      end else if (strobe.wrLat) begin
        pinLat <= busWrData[PIN_COUNT-1:0];
      end
      if (strobe.wrLat) serOd <= busWrData[REG_WIDTH-1:PIN_COUNT+1];
      if (strobe.wrDir) dirReg <= busWrData;
    end
  end

  assign pullUpEnN  = pullBits;
  assign periphOdEn = dirReg[REG_WIDTH-1:PIN_COUNT];
  assign serialOdEn = serOd;

  always_comb begin
    unique case (strobe.rdSel)
      ADDR_DATA: busRdData = {pullBits, syncB};
      ADDR_DIR:  busRdData = dirReg;
      ADDR_LAT:  busRdData = {serOd, 1'b0, pinLat};
      default:   busRdData = '0;
    endcase
  end

  // Per-pin output path: override first, then registers, then open-drain shaping.
  for (genvar i = 0; i < PIN_COUNT; i++) begin : gPin
    logic effDir, effOut, odMode;
    assign effDir = ovrEn[i] ? ovrDir[i] : dirReg[i];
    assign effOut = ovrEn[i] ? ovrOut[i] : pinLat[i];
    if (i == OD_PIN) begin : gOd
      assign odMode = serialOwnsPin1 & serOd[SER_OD_W-1];
    end else begin : gPlain
      assign odMode = 1'b0;
    end
    assign padOe[i]  = odMode ? (~effDir & ~effOut) : ~effDir;
    assign padOut[i] = odMode ? 1'b0 : effOut;
  end
endmodule

// File: rtl/gpio_five_pin_port.sv
module gpio_five_pin_port
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 5,
  parameter int REG_WIDTH = 8,
  parameter int OD_PIN    = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           busAddr,
  input  logic                 busWrEn,
  input  logic [REG_WIDTH-1:0] busWrData,
  output logic [REG_WIDTH-1:0] busRdData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  input  logic [PIN_COUNT-1:0] ovrEn,
  input  logic [PIN_COUNT-1:0] ovrDir,
  input  logic [PIN_COUNT-1:0] ovrOut,
  input  logic                 serialOwnsPin1,
  output logic [REG_WIDTH-PIN_COUNT-1:0] pullUpEnN,
  output logic [REG_WIDTH-PIN_COUNT-1:0] periphOdEn,
  output logic [REG_WIDTH-PIN_COUNT-2:0] serialOdEn
);
  ctrlStrobeT strobe;

  gpio_port_ctrl uCtrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobe (strobe)
  );

  gpio_port_datapath #(
    .PIN_COUNT(PIN_COUNT),
    .REG_WIDTH(REG_WIDTH),
    .OD_PIN   (OD_PIN)
  ) uPath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .busWrData     (busWrData),
    .busRdData     (busRdData),
    .padIn         (padIn),
    .padOut        (padOut),
    .padOe         (padOe),
    .ovrEn         (ovrEn),
    .ovrDir        (ovrDir),
    .ovrOut        (ovrOut),
    .serialOwnsPin1(serialOwnsPin1),
    .pullUpEnN     (pullUpEnN),
    .periphOdEn    (periphOdEn),
    .serialOdEn    (serialOdEn)
  );
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
  parameter int PIN_COUNT = 5,
  parameter int REG_WIDTH = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           busAddr,
  input logic                 busWrEn,
  input logic [REG_WIDTH-1:0] busWrData,
  input logic [REG_WIDTH-1:0] busRdData,
  input logic [PIN_COUNT-1:0] padOut,
  input logic [PIN_COUNT-1:0] padOe,
  input logic [PIN_COUNT-1:0] ovrEn,
  input logic [PIN_COUNT-1:0] ovrDir,
  input logic [PIN_COUNT-1:0] ovrOut,
  input logic                 serialOwnsPin1,
  input logic [REG_WIDTH-PIN_COUNT-1:0] pullUpEnN,
  input logic [REG_WIDTH-PIN_COUNT-1:0] periphOdEn,
  input logic [REG_WIDTH-PIN_COUNT-2:0] serialOdEn
);
  // R5
  pull_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd0) |=> pullUpEnN == $past(busWrData[REG_WIDTH-1:PIN_COUNT]));

  // R6
  periph_od_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd1) |=> periphOdEn == $past(busWrData[REG_WIDTH-1:PIN_COUNT]));

  // R7
  serial_od_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd2) |=> serialOdEn == $past(busWrData[REG_WIDTH-1:PIN_COUNT+1]));

  // R7
  lat_hole_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd2) |-> busRdData[PIN_COUNT] == 1'b0);

  // R8
  override_pin0_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovrEn[0] |-> (padOe[0] == !ovrDir[0]) && (padOut[0] == ovrOut[0]));

  // R10
  od_pin1_no_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serialOwnsPin1 && serialOdEn[REG_WIDTH-PIN_COUNT-2]) |-> padOut[1] == 1'b0);

  // R11
  none_addr_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd3) |-> busRdData == '0);
endmodule

bind gpio_five_pin_port gpio_port_checker #(
  .PIN_COUNT(PIN_COUNT),
  .REG_WIDTH(REG_WIDTH)
) chk (.*);

// File: tb/gpio_five_pin_port_test.sv
`timescale 1ns/1ps
module gpio_five_pin_port_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic [4:0] padIn = 5'h00;
  logic [4:0] padOut, padOe;
  logic [4:0] ovrEn = 5'h00, ovrDir = 5'h00, ovrOut = 5'h00;
  logic       serialOwnsPin1 = 1'b0;
  logic [2:0] pullUpEnN, periphOdEn;
  logic [1:0] serialOdEn;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  gpio_five_pin_port uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .ovrEn(ovrEn), .ovrDir(ovrDir),
    .ovrOut(ovrOut), .serialOwnsPin1(serialOwnsPin1), .pullUpEnN(pullUpEnN),
    .periphOdEn(periphOdEn), .serialOdEn(serialOdEn)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    busAddr = a;
    #0.5;
    v = busRdData;
  endtask

  task automatic testReset();
    logic [7:0] v;
    busRead(2'd1, v); check("R1 dir reset", v, 8'h1F);
    busRead(2'd2, v); check("R1 latch reset", v, 8'h00);
    busRead(2'd0, v); check("R1 data upper reset", {5'b0, v[7:5]}, 8'h07);
    check("R1 pullUpEnN", {5'b0, pullUpEnN}, 8'h07);
    check("R1 periphOdEn", {5'b0, periphOdEn}, 8'h00);
    check("R1 serialOdEn", {6'b0, serialOdEn}, 8'h00);
    check("R1 padOe", {3'b0, padOe}, 8'h00);
  endtask

  task automatic testDirection();
    busWrite(2'd2, 8'h0A);
    busWrite(2'd1, 8'h1C);
    #0.5;
    check("R2 padOe", {3'b0, padOe}, 8'h03);
    check("R2 padOut low pins", {6'b0, padOut[1:0]}, 8'h02);
  endtask

  task automatic testLatchWrites();
    logic [7:0] v;
    busWrite(2'd0, 8'hF5);
    busRead(2'd2, v); check("R3 data write to latch", {3'b0, v[4:0]}, 8'h15);
    busWrite(2'd2, 8'h0C);
    busRead(2'd2, v); check("R3 latch write", v, 8'h0C);
    busWrite(2'd0, 8'hE0);
    busRead(2'd2, v); check("R3 data clear latch", v, 8'h00);
  endtask

  task automatic testSync();
    @(negedge clk);
    busAddr = 2'd0; padIn = 5'h15;
    @(posedge clk); #1;
    check("R4 one edge old", {3'b0, busRdData[4:0]}, 8'h00);
    @(posedge clk); #1;
    check("R4 two edges new", {3'b0, busRdData[4:0]}, 8'h15);
    padIn = 5'h00;
  endtask

  task automatic testPullUps();
    logic [7:0] v;
    busWrite(2'd0, 8'h40);
    #0.5; check("R5 pullUpEnN", {5'b0, pullUpEnN}, 8'h02);
    busRead(2'd0, v); check("R5 readback", {5'b0, v[7:5]}, 8'h02);
    busWrite(2'd0, 8'hE0);
  endtask

  task automatic testPeriphOd();
    logic [7:0] v;
    busWrite(2'd1, 8'hBF);
    #0.5; check("R6 periphOdEn", {5'b0, periphOdEn}, 8'h05);
    busRead(2'd1, v); check("R6 readback", v, 8'hBF);
  endtask

  task automatic testSerialOd();
    logic [7:0] v;
    busWrite(2'd2, 8'h60);
    #0.5; check("R7 serialOdEn", {6'b0, serialOdEn}, 8'h01);
    busRead(2'd2, v); check("R7 bit5 reads 0", v, 8'h40);
    busWrite(2'd2, 8'h00);
  endtask

  task automatic testOverride();
    logic [7:0] v;
    busWrite(2'd1, 8'h1F);
    busWrite(2'd2, 8'h00);
    @(negedge clk);
    ovrEn = 5'h11; ovrDir = 5'h00; ovrOut = 5'h10;
    #0.5;
    check("R8 override oe", {3'b0, padOe}, 8'h11);
    check("R8 override out", {3'b0, padOut & 5'h11}, 8'h10);
    busRead(2'd1, v); check("R9 dir kept during override", v, 8'h1F);
    busWrite(2'd1, 8'h1E);
    busRead(2'd1, v); check("R9 rmw value", v, 8'h1E);
    @(negedge clk);
    ovrEn = 5'h00;
    busRead(2'd1, v); check("R9 dir after override", v, 8'h1E);
    busWrite(2'd1, 8'h1F);
  endtask

  task automatic testOpenDrain();
    busWrite(2'd2, 8'h82);
    busWrite(2'd1, 8'h1D);
    @(negedge clk);
    serialOwnsPin1 = 1'b1;
    #0.5;
    check("R10 od high released", {6'b0, padOe[1], padOut[1]}, 8'h00);
    busWrite(2'd2, 8'h80);
    #0.5;
    check("R10 od low driven", {6'b0, padOe[1], padOut[1]}, 8'h02);
    @(negedge clk);
    serialOwnsPin1 = 1'b0;
    busWrite(2'd2, 8'h02);
    #0.5;
    check("R10 push-pull when not owned", {6'b0, padOe[1], padOut[1]}, 8'h03);
    busWrite(2'd1, 8'h1F);
    busWrite(2'd2, 8'h00);
  endtask

  task automatic testNoneAddr();
    logic [7:0] v;
    busWrite(2'd3, 8'hFF);
    busRead(2'd3, v); check("R11 addr3 reads 0", v, 8'h00);
    busRead(2'd1, v); check("R11 dir untouched", v, 8'h1F);
    busRead(2'd2, v); check("R11 latch untouched", v, 8'h00);
    busRead(2'd0, v); check("R11 data upper untouched", {5'b0, v[7:5]}, 8'h07);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDirection();
    testLatchWrites();
    testSync();
    testPullUps();
    testPeriphOd();
    testSerialOd();
    testOverride();
    testOpenDrain();
    testNoneAddr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule